// File: doc/BRIEF.md
# Serial TDM Highway Receiver

This block receives one serial time-division-multiplexed highway that runs synchronously to a master bit clock. The highway carries a repeating frame of 8-bit time slots. A frame-sync pulse marks where each frame begins, and the block counts slot numbers and bit positions from the point where it detects that pulse. The block turns the serial stream into bytes. Each completed slot appears on the outputs as a byte with its slot number, a one-cycle valid strobe, and a flag that marks slot 0.

The master clock runs at either 8.192 MHz or 16.384 MHz, and a static input tells the block which one is in use. The line rate can be set to 2.048, 4.096, 8.192 or 16.384 Mbit/s. The block derives a bit period of N master clocks from these two settings and samples each data bit at the middle of its period. The sync polarity and the clock edge that samples the sync are both set by static inputs. If a sync is detected anywhere other than the first clock of a frame, the block flags a framing error and restarts its counters from that sync.

Top module: `tdm_rx_deser`

## Requirements
- R1: While reset is held, and after it is released, slot_byte, slot_idx, slot_vld, frame_start and frame_err are 0. slot_vld stays 0 until the first frame sync has been detected, whatever arrives on sdin.
- R2: The sync is active when fsync_in equals cfg_sync_pol (1 = active-high, 0 = active-low). A detection happens only on a change from inactive to active. A sync held active for several clocks counts as one detection.
- R3: With cfg_sync_fall=0, fsync_in is sampled on rising clock edges, and a sync first sampled active at rising edge X is detected at rising edge X+1. With cfg_sync_fall=1, fsync_in is sampled on falling edges, and a sync first sampled active at a falling edge is detected at the next rising edge.
- R4: The bit period is N = 2^(2 + cfg_fast_clk − cfg_rate) clocks. cfg_fast_clk is 0 for an 8.192 MHz clock and 1 for 16.384 MHz. cfg_rate codes 0, 1, 2, 3 select 2.048, 4.096, 8.192 and 16.384 Mbit/s. If the detection happens at edge E, bit k of the frame is sampled from sdin at rising edge E + k·N + floor(N/2).
- R5: Each slot consists of 8 consecutive frame bits, and the first bit received becomes slot_byte bit 7 (MSB first).
- R6: slot_vld is high for exactly the one cycle after the edge that samples the eighth bit of a slot. In that same cycle, slot_byte holds the byte and slot_idx holds the slot number (0 for the first slot after the sync).
- R7: A frame holds 2^(BASE_SLOTS_LOG2 + cfg_rate) slots (32, 64, 128 or 256 with the default BASE_SLOTS_LOG2 = 5). The slot index wraps to 0 after the last slot and keeps counting without a new sync.
- R8: frame_start is high together with slot_vld exactly when slot_idx is 0.
- R9: A sync detected at the first clock of the next frame (E + frame length) causes no error, and the output sequence continues unchanged. A sync detected at any other point raises frame_err for one cycle after its detection edge, and all counters restart with that edge as the new E.
- R10: The first sync detected after reset never raises frame_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fast_clk | input | 1 | 0: 8.192 MHz clock, 1: 16.384 MHz clock |
| cfg_rate | input | 2 | Line rate code, 0..3 = 2.048..16.384 Mbit/s |
| cfg_sync_pol | input | 1 | Active level of fsync_in |
| cfg_sync_fall | input | 1 | 1: sample fsync_in on falling clock edges |
| sdin | input | 1 | Serial highway data |
| fsync_in | input | 1 | Frame sync |
| slot_byte | output | 8 | Received slot byte |
| slot_idx | output | BASE_SLOTS_LOG2+3 | Slot number of slot_byte |
| slot_vld | output | 1 | One-cycle strobe for slot_byte and slot_idx |
| frame_start | output | 1 | Marks the slot-0 byte |
| frame_err | output | 1 | One-cycle pulse for a sync at an unexpected position |

## Verification
The bench builds the block with BASE_SLOTS_LOG2 = 1, so a frame holds 2 to 16 slots and lasts only 64 or 128 clocks. This lets a short run cover every valid pairing of clock setting and line rate (N from 1 to 8), both sync polarities and both sync sampling edges. Each run spans a full frame, a resync at either the expected boundary or a point in mid-frame, and the whole frame that follows. At these sizes the exact sampling cycle of every byte can be predicted, and so can the loss of partly received slots when a misplaced sync arrives.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int BYTE_W       = 8;
  localparam int BIT_CNT_W    = 3;
  localparam int DIV_LOG2_MAX = 3;
  localparam int DIV_SH_W     = 2;
  localparam int PH_W         = DIV_LOG2_MAX;

  // log2 of the clocks per bit, floored at zero
  function automatic logic [DIV_SH_W-1:0] div_shift(input logic fast, input logic [1:0] rate);
    int s;
    s = 2 + int'(fast) - int'(rate);
    if (s < 0) s = 0;
    if (s > DIV_LOG2_MAX) s = DIV_LOG2_MAX;
    return DIV_SH_W'(s);
  endfunction

  function automatic logic [PH_W-1:0] phase_last(input logic [DIV_SH_W-1:0] sh);
    logic [PH_W:0] n;
    n = (PH_W+1)'(1) << sh;
    n = n - 1'b1;
    return n[PH_W-1:0];
  endfunction

  function automatic logic [PH_W-1:0] phase_mid(input logic [DIV_SH_W-1:0] sh);
    logic [PH_W:0] n;
    n = ((PH_W+1)'(1) << sh) >> 1;
    return n[PH_W-1:0];
  endfunction
endpackage

// File: rtl/tdm_sync_detect.sv
module tdm_sync_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_pol,
  input  logic cfg_fall,
  input  logic fsync_in,
  output logic sync_det
);
  logic raw_rise;
  logic raw_fall;
  logic act_prev;
  logic act_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_rise <= 1'b0;
    else        raw_rise <= fsync_in;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) raw_fall <= 1'b0;
    else        raw_fall <= fsync_in;
  end

  assign act_now = ((cfg_fall ? raw_fall : raw_rise) == cfg_pol);

  // previous-active starts set so that reset never looks like an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= 1'b1;
    else        act_prev <= act_now;
  end

  assign sync_det = act_now & ~act_prev;
endmodule

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer
  import tdm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_SH_W-1:0] div_sh,
  input  logic                restart,
  output logic                mid_hit,
  output logic                last_hit,
  output logic                at_bit_start
);
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] cur;

  assign cur          = restart ? '0 : ph;
  assign mid_hit      = (cur == phase_mid(div_sh));
  assign last_hit     = (cur == phase_last(div_sh));
  assign at_bit_start = (ph == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ph <= '0;
    else if (last_hit) ph <= '0;
    else               ph <= PH_W'(cur + 1'b1);
  end
endmodule

// File: rtl/tdm_slot_assembler.sv
module tdm_slot_assembler
  import tdm_rx_pkg::*;
#(
  parameter int BASE_SLOTS_LOG2 = 5,
  localparam int SW = BASE_SLOTS_LOG2 + 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_rate,
  input  logic              restart,
  input  logic              mid_hit,
  input  logic              last_hit,
  input  logic              at_bit_start,
  input  logic              sdin,
  output logic [BYTE_W-1:0] slot_byte,
  output logic [SW-1:0]     slot_idx,
  output logic              slot_vld,
  output logic              frame_start,
  output logic              frame_err,
  output logic              at_frame_boundary
);
  logic                 aligned;
  logic [BIT_CNT_W-1:0] bitc;
  logic [SW-1:0]        slot;
  logic [BYTE_W-2:0]    shreg;
  logic [BIT_CNT_W-1:0] bit_pos;
  logic [SW-1:0]        slot_pos;
  logic [SW-1:0]        slot_last_val;
  logic                 live;
  logic                 byte_done;

  assign bit_pos           = restart ? '0 : bitc;
  assign slot_pos          = restart ? '0 : slot;
  assign slot_last_val     = SW'((1 << (BASE_SLOTS_LOG2 + int'(cfg_rate))) - 1);
  assign live              = aligned | restart;
  assign byte_done         = (bit_pos == '1);
  assign at_frame_boundary = at_bit_start && (bitc == '0) && (slot == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned     <= 1'b0;
      bitc        <= '0;
      slot        <= '0;
      shreg       <= '0;
      slot_byte   <= '0;
      slot_idx    <= '0;
      slot_vld    <= 1'b0;
      frame_start <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      slot_vld    <= 1'b0;
      frame_start <= 1'b0;
      frame_err   <= restart & aligned & ~at_frame_boundary;
      if (restart) begin
        aligned <= 1'b1;
        bitc    <= '0;
        slot    <= '0;
      end
      if (live && mid_hit) begin
        shreg <= {shreg[BYTE_W-3:0], sdin};
        if (byte_done) begin
          slot_byte   <= {shreg, sdin};
          slot_idx    <= slot_pos;
          slot_vld    <= 1'b1;
          frame_start <= (slot_pos == '0);
        end
      end
      if (live && last_hit) begin
        bitc <= BIT_CNT_W'(bit_pos + 1'b1);
        if (byte_done) slot <= (slot_pos == slot_last_val) ? '0 : SW'(slot_pos + 1'b1);
      end
    end
  end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_rx_pkg::*;
#(
  parameter int BASE_SLOTS_LOG2 = 5
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_fast_clk,
  input  logic [1:0]                 cfg_rate,
  input  logic                       cfg_sync_pol,
  input  logic                       cfg_sync_fall,
  input  logic                       sdin,
  input  logic                       fsync_in,
  output logic [7:0]                 slot_byte,
  output logic [BASE_SLOTS_LOG2+2:0] slot_idx,
  output logic                       slot_vld,
  output logic                       frame_start,
  output logic                       frame_err
);
  logic                sync_det;
  logic                mid_hit;
  logic                last_hit;
  logic                at_bit_start;
  logic                at_frame_boundary;
  logic [DIV_SH_W-1:0] div_sh;

  assign div_sh = div_shift(cfg_fast_clk, cfg_rate);

  tdm_sync_detect u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_pol  (cfg_sync_pol),
    .cfg_fall (cfg_sync_fall),
    .fsync_in (fsync_in),
    .sync_det (sync_det)
  );

  tdm_bit_timer u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_sh       (div_sh),
    .restart      (sync_det),
    .mid_hit      (mid_hit),
    .last_hit     (last_hit),
    .at_bit_start (at_bit_start)
  );

  tdm_slot_assembler #(.BASE_SLOTS_LOG2(BASE_SLOTS_LOG2)) u_asm (
    .clk               (clk),
    .rst_n             (rst_n),
    .cfg_rate          (cfg_rate),
    .restart           (sync_det),
    .mid_hit           (mid_hit),
    .last_hit          (last_hit),
    .at_bit_start      (at_bit_start),
    .sdin              (sdin),
    .slot_byte         (slot_byte),
    .slot_idx          (slot_idx),
    .slot_vld          (slot_vld),
    .frame_start       (frame_start),
    .frame_err         (frame_err),
    .at_frame_boundary (at_frame_boundary)
  );
endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk #(
  parameter int BASE_SLOTS_LOG2 = 5
)(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sync_det,
  input logic                       mid_hit,
  input logic                       slot_vld,
  input logic                       frame_start,
  input logic                       frame_err,
  input logic [1:0]                 cfg_rate,
  input logic [BASE_SLOTS_LOG2+2:0] slot_idx
);
  logic seen_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_sync <= 1'b0;
    else if (sync_det) seen_sync <= 1'b1;
  end

  // R1
  vld_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |-> seen_sync);

  // R2
  det_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_det |=> !sync_det);

  // R4
  vld_on_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |-> $past(mid_hit));

  // R6
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |=> !slot_vld);

  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |-> (int'(slot_idx) < (1 << (BASE_SLOTS_LOG2 + int'(cfg_rate)))));

  // R8
  fstart_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (slot_vld && slot_idx == '0));

  // R9
  ferr_after_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(sync_det));
endmodule

bind tdm_rx_deser tdm_rx_chk #(.BASE_SLOTS_LOG2(BASE_SLOTS_LOG2)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_det    (sync_det),
  .mid_hit     (mid_hit),
  .slot_vld    (slot_vld),
  .frame_start (frame_start),
  .frame_err   (frame_err),
  .cfg_rate    (cfg_rate),
  .slot_idx    (slot_idx)
);

// File: tb/tdm_rx_deser_tb.sv
module tdm_rx_deser_tb;
  localparam int BL = 1;
  localparam int SW = BL + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_fast_clk = 1'b1;
  logic [1:0]    cfg_rate = 2'd0;
  logic          cfg_sync_pol = 1'b1;
  logic          cfg_sync_fall = 1'b0;
  logic          sdin = 1'b0;
  logic          fsync_in = 1'b0;
  logic [7:0]    slot_byte;
  logic [SW-1:0] slot_idx;
  logic          slot_vld;
  logic          frame_start;
  logic          frame_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [7:0]    mon_byte [64];
  logic [SW-1:0] mon_idx  [64];
  logic          mon_fs   [64];
  int            mon_cyc  [64];
  int            mon_n = 0;
  int            err_n = 0;
  int            err_cyc = 0;

  // fields: fast, rate, pol, fall, misplaced, seed
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 8'd5},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'd17},
    {1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 8'd33},
    {1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 8'd71},
    {1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'd9},
    {1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 8'd44},
    {1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 8'd90},
    {1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 8'd120}
  };

  tdm_rx_deser #(.BASE_SLOTS_LOG2(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fast_clk(cfg_fast_clk), .cfg_rate(cfg_rate),
    .cfg_sync_pol(cfg_sync_pol), .cfg_sync_fall(cfg_sync_fall), .sdin(sdin),
    .fsync_in(fsync_in), .slot_byte(slot_byte), .slot_idx(slot_idx),
    .slot_vld(slot_vld), .frame_start(frame_start), .frame_err(frame_err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (slot_vld) begin
        if (mon_n < 64) begin
          mon_byte[mon_n] = slot_byte;
          mon_idx[mon_n]  = slot_idx;
          mon_fs[mon_n]   = frame_start;
          mon_cyc[mon_n]  = cyc;
        end
        mon_n = mon_n + 1;
      end
      if (frame_err) begin
        err_n   = err_n + 1;
        err_cyc = cyc;
      end
    end
  end

  initial begin
    #(4 * 190000);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [7:0] pat(input int seed, input int fr, input int s);
    int v;
    v = seed * 29 + fr * 101 + s * 53;
    return 8'(v) ^ 8'(s << 3);
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic fast, input logic [1:0] rate, input logic pol, input logic fall);
    rst_n = 1'b0;
    cfg_fast_clk = fast; cfg_rate = rate; cfg_sync_pol = pol; cfg_sync_fall = fall;
    fsync_in = ~pol; sdin = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 mon_n = 0; err_n = 0;
  endtask

  task automatic run_case(input logic fast, input logic [1:0] rate, input logic pol,
                          input logic fall, input logic mis, input int seed, input int w);
    int n, nsl, len, off, j2, j0, e, last_j;
    n   = 1 << (2 + int'(fast) - int'(rate));
    nsl = (1 << BL) << rate;
    len = nsl * 8 * n;
    off = fall ? 0 : 1;
    j2  = mis ? (len / 2 + 3) : len;
    last_j = j2 + len + off + 2;
    do_reset(fast, rate, pol, fall);
    j0 = 0;
    for (int j = 0; j <= last_j; j++) begin
      @(posedge clk); #1;
      if (j == 0) j0 = cyc;
      fsync_in = ((j < w) || (j >= j2 && j < j2 + w)) ? pol : ~pol;
      begin
        int b, fr, k;
        fr = (j >= j2 + off) ? 1 : 0;
        b  = fr ? (j - j2 - off) : (j - off);
        if (b < 0 || b >= len) sdin = 1'b0;
        else begin
          k = b / n;
          sdin = pat(seed, fr, k / 8)[7 - (k % 8)];
        end
      end
    end
    repeat (2) @(posedge clk);
    #1;
    e = 0;
    for (int fr = 0; fr < 2; fr++) begin
      for (int s = 0; s < nsl; s++) begin
        int rel;
        rel = (fr == 1 ? j2 : 0) + (8 * s + 7) * n + n / 2;
        if (fr == 0 && rel >= j2) continue;
        if (e < mon_n && e < 64) begin
          check(mon_byte[e] == pat(seed, fr, s), "R5 slot byte (MSB first)", mon_byte[e], pat(seed, fr, s));
          check(mon_idx[e] == SW'(s), "R6 slot index", mon_idx[e], s);
          check(mon_fs[e] == (s == 0), "R8 frame_start with slot 0", mon_fs[e], (s == 0));
          check(mon_cyc[e] == j0 + off + 1 + rel, "R3 R4 slot_vld cycle", mon_cyc[e] - j0, off + 1 + rel);
        end else check(1'b0, "R7 missing slot output", mon_n, e + 1);
        e++;
      end
    end
    check(mon_n == e, "R7 slot count over frames", mon_n, e);
    if (mis) begin
      check(err_n == 1, "R9 frame_err on misplaced sync", err_n, 1);
      check(err_cyc == j0 + j2 + off + 1, "R9 frame_err cycle", err_cyc - j0, j2 + off + 1);
    end else begin
      check(err_n == 0, "R9 R10 no frame_err at boundary or first sync", err_n, 0);
    end
  endtask

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(slot_vld == 0 && frame_start == 0 && frame_err == 0, "R1 flags in reset",
          {slot_vld, frame_start, frame_err}, 0);
    check(slot_byte == 0 && slot_idx == 0, "R1 data in reset", slot_byte, 0);

    // R1: no output before the first sync, even with data toggling
    do_reset(1'b1, 2'd3, 1'b1, 1'b0);
    for (int j = 0; j < 300; j++) begin
      @(posedge clk); #1;
      sdin = j[0] ^ j[2];
    end
    check(mon_n == 0, "R1 no slot_vld before sync", mon_n, 0);
    check(err_n == 0, "R10 no frame_err without sync", err_n, 0);

    // table of configurations: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 8; v++) begin
      run_case(VEC[v][13], VEC[v][12:11], VEC[v][10], VEC[v][9], VEC[v][8], int'(VEC[v][7:0]), 1);
    end

    // R2: wide sync pulse counts once, both polarities
    run_case(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 61, 6);
    run_case(1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 77, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule